// File: doc/BRIEF.md
# Dual-Channel Redundant Transmit Dispatcher

This block sits between a frame producer and two independent CAN controller channels. It takes outgoing frames on a valid/ready input and places each one in one of two small transmit mailboxes, one per channel. Each channel's controller takes frames from the head of its mailbox. Channel 1 (index 0) is the primary channel and channel 2 (index 1) is its backup. When both channels are healthy, traffic goes to the primary. The backup takes frames when the primary's mailbox fills, and it also takes frames when it has sat idle while the primary still had work queued.

Each controller reports its error-passive and bus-off conditions, which the block merges into one fault per channel, together with its transmit error counter. When a channel becomes faulted, the frames still waiting in its mailbox are moved one per cycle to the tail of the other channel's mailbox. New input is held off until this move is complete, so no frame is lost and none overtakes an older one. While a channel is faulted, the block requests a test frame on it at a fixed interval. At each of those requests it checks whether the channel can return to service. If both channels are faulted, input is stalled and an all-down flag is raised.

Top module: `dual_bus_dispatch`

## Requirements
- R1: After reset both mailboxes are empty, no channel is faulted, `in_ready` is high, `all_down` is low and no strobe is active.
- R2: With both channels healthy, an accepted frame goes to channel index 0 unless that mailbox holds DEPTH frames (or R4 applies), in which case it goes to index 1. `in_ready` is low when the selected mailbox is full. `ch_push[i]` pulses in the cycle a frame is written to mailbox i.
- R3: Each mailbox holds at most DEPTH (default 3) frames and presents them in arrival order on `ch_head_data[i]`. `ch_sent[i]` removes the head only while `ch_head_valid[i]` is high, and has no effect otherwise.
- R4: With both channels healthy, consider the cycles in which mailbox 1 is empty while mailbox 0 is not. Once IDLE_CYCLES such cycles have occurred in a row, the next accepted frame goes to mailbox 1 if mailbox 1 is still empty.
- R5: A channel whose error-passive or bus-off input is high is faulted (`ch_fault[i]` = 1) from the next cycle on. While a channel is faulted, its `ch_head_valid` is low.
- R6: While one channel is faulted, the other is healthy, and the faulted mailbox is not empty, the faulted mailbox's head moves to the tail of the healthy mailbox once per cycle, whenever that mailbox has room. `ch_recall` of the faulted channel pulses on each move, and `in_ready` stays low until the faulted mailbox is empty.
- R7: While exactly one channel is faulted, every new frame goes to the healthy channel.
- R8: While channel i is faulted, `ch_probe[i]` pulses once every POLL_CYCLES cycles, first in the POLL_CYCLES-th cycle of the fault. It never pulses on a healthy channel.
- R9: A faulted channel returns to service in the cycle after a probe cycle in which its error-passive and bus-off inputs are low and its transmit error counter is below 128. Otherwise it stays faulted.
- R10: While both channels are faulted, `all_down` is high, `in_ready` is low, and all frames are held in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Producer offers a frame |
| in_ready | output | 1 | Frame accepted this cycle when high together with `in_valid` |
| in_data | input | DATA_W | Frame payload |
| ch_epass | input | 2 | Per-channel error-passive indication |
| ch_boff | input | 2 | Per-channel bus-off indication |
| ch_tec | input | 2 x TEC_W | Per-channel transmit error counter |
| ch_head_valid | output | 2 | Mailbox head available to the channel's controller |
| ch_head_data | output | 2 x DATA_W | Mailbox head frame per channel |
| ch_sent | input | 2 | Controller finished the head frame; removes it |
| ch_push | output | 2 | A frame was written into the channel's mailbox |
| ch_recall | output | 2 | A pending frame was read back from the channel's mailbox for migration |
| ch_probe | output | 2 | Request for an empty test frame on a faulted channel |
| ch_fault | output | 2 | Channel is out of service |
| all_down | output | 1 | Both channels are faulted |

## Verification
`in_ready`, `ch_push`, `ch_recall` and `ch_probe` respond in the same cycle as the inputs and state that cause them. Mailbox contents, `ch_head_valid`, `ch_fault` and `all_down` change one clock edge after the frame, sent pulse or fault input that causes them. A fault input seen at one edge gates the head and starts migration in the next cycle, and recovery takes effect one cycle after the probe that allows it. The bench drives inputs just after each rising edge and applies the same edge to a queue-based model. It then compares every output with the model on the falling edge, so both same-cycle and one-edge results are checked in exactly the cycle they are due.

// File: rtl/dd_pkg.sv
// Shared constants for the dual-channel dispatcher.
// Assumes exactly two channels; index 0 is the primary channel.
package dd_pkg;
    localparam int NCH       = 2;
    localparam int PRIMARY   = 0;
    localparam int BACKUP    = 1;
endpackage

// File: rtl/dd_mailbox.sv
// Per-channel transmit mailbox: a small FIFO of DEPTH frames.
// Assumes the caller never pushes into a full box without a pop
// and never pops an empty box; assertions guard both.
module dd_mailbox #(
    parameter int W     = 16,
    parameter int DEPTH = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [W-1:0]                push_data,
    input  logic                        pop,
    output logic                        head_valid,
    output logic [W-1:0]                head_data,
    output logic [$clog2(DEPTH+1)-1:0]  count
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     slot [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (push) slot[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Head presentation.
    assign head_valid = (count != '0);
    assign head_data  = slot[rd_ptr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count < CNT_W'(DEPTH))); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0)); // R3
endmodule

// File: rtl/dd_health.sv
// Per-channel health tracker: merges error-passive and bus-off into one
// fault, issues a test-frame request every POLL_CYCLES while faulted and
// clears the fault at a request when the channel looks clean again.
module dd_health #(
    parameter int TEC_W       = 9,
    parameter int POLL_CYCLES = 1000,
    parameter int TEC_LIMIT   = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             epass,
    input  logic             boff,
    input  logic [TEC_W-1:0] tec,
    output logic             fault,
    output logic             probe
);
    localparam int PW = $clog2(POLL_CYCLES + 1);

    logic [PW-1:0] poll_cnt;
    logic          bad;
    logic          clean;

    // Merged fault condition and recovery condition.
    assign bad   = epass | boff;
    assign clean = !bad && (tec < TEC_W'(TEC_LIMIT));
    assign probe = fault && (poll_cnt == PW'(POLL_CYCLES - 1));

    // Fault flag: set on any bad indication, cleared only at a probe.
    always_ff @(posedge clk) begin
        if (!rst_n)              fault <= 1'b0;
        else if (bad)            fault <= 1'b1;
        else if (probe && clean) fault <= 1'b0;
    end

    // Poll interval counter, running only while faulted.
    always_ff @(posedge clk) begin
        if (!rst_n || !fault || probe) poll_cnt <= '0;
        else                           poll_cnt <= poll_cnt + 1'b1;
    end

    AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> fault); // R5
    AST_PROBE_FAULTED: assert property (@(posedge clk) disable iff (!rst_n)
        probe |-> fault); // R8
    AST_RECOVER_AT_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> $past(probe)); // R9
endmodule

// File: rtl/dd_route.sv
// Routing decision: migration of a faulted channel's pending frames,
// primary-first placement with overflow, idle-based balancing to the
// backup, and input stall. Purely combinational except the idle streak.
module dd_route #(
    parameter int DEPTH       = 3,
    parameter int IDLE_CYCLES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(DEPTH+1)-1:0] cnt0,
    input  logic [$clog2(DEPTH+1)-1:0] cnt1,
    input  logic [1:0]                 fault,
    input  logic                       in_valid,
    output logic                       in_ready,
    output logic [1:0]                 enq,
    output logic [1:0]                 recall
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int SW    = $clog2(IDLE_CYCLES + 1);

    logic [SW-1:0] streak;
    logic          full0, full1, both_ok, mig_pend, balance, to_backup;
    logic [1:0]    in_enq;

    assign full0   = (cnt0 == CNT_W'(DEPTH));
    assign full1   = (cnt1 == CNT_W'(DEPTH));
    assign both_ok = !fault[0] && !fault[1];

    // Migration: faulted box with content and a healthy partner.
    always_comb begin
        recall[0] = fault[0] && !fault[1] && (cnt0 != '0) && !full1;
        recall[1] = fault[1] && !fault[0] && (cnt1 != '0) && !full0;
        mig_pend  = (fault[0] && !fault[1] && (cnt0 != '0)) ||
                    (fault[1] && !fault[0] && (cnt1 != '0));
    end

    // Input placement and readiness.
    assign balance   = (streak == SW'(IDLE_CYCLES)) && (cnt1 == '0);
    assign to_backup = full0 || balance;
    always_comb begin
        in_ready = 1'b0;
        in_enq   = 2'b00;
        if (!mig_pend) begin
            if (both_ok) begin
                in_ready = to_backup ? !full1 : !full0;
                in_enq   = to_backup ? 2'b10 : 2'b01;
            end else if (!fault[0]) begin
                in_ready = !full0;
                in_enq   = 2'b01;
            end else if (!fault[1]) begin
                in_ready = !full1;
                in_enq   = 2'b10;
            end
        end
        enq = ({2{in_valid && in_ready}} & in_enq) | {recall[0], recall[1]};
    end

    // Idle streak of the backup box while the primary holds work.
    always_ff @(posedge clk) begin
        if (!rst_n || !both_ok || cnt1 != '0 || cnt0 == '0) streak <= '0;
        else if (streak != SW'(IDLE_CYCLES))                streak <= streak + 1'b1;
    end

    AST_HOLD_DURING_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (recall != 2'b00) |-> !in_ready); // R6
    AST_SINGLE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(recall)); // R6
endmodule

// File: rtl/dual_bus_dispatch.sv
// Top of the dual-channel redundant transmit dispatcher. Two mailboxes,
// two health trackers and one router. Index 0 is the primary channel.
// Assumes the controllers pulse ch_sent only for a presented head frame;
// stray pulses are masked.
module dual_bus_dispatch #(
    parameter int DATA_W      = 16,
    parameter int DEPTH       = 3,
    parameter int TEC_W       = 9,
    parameter int POLL_CYCLES = 1000,
    parameter int IDLE_CYCLES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [DATA_W-1:0]           in_data,
    input  logic [1:0]                  ch_epass,
    input  logic [1:0]                  ch_boff,
    input  logic [1:0][TEC_W-1:0]       ch_tec,
    output logic [1:0]                  ch_head_valid,
    output logic [1:0][DATA_W-1:0]      ch_head_data,
    input  logic [1:0]                  ch_sent,
    output logic [1:0]                  ch_push,
    output logic [1:0]                  ch_recall,
    output logic [1:0]                  ch_probe,
    output logic [1:0]                  ch_fault,
    output logic                        all_down
);
    import dd_pkg::*;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [NCH-1:0]             box_valid;
    logic [CNT_W-1:0]           box_cnt [NCH];
    logic [NCH-1:0]             box_pop;
    logic [NCH-1:0][DATA_W-1:0] box_wdata;

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            // Write data: migrated frame from the partner, else new input.
            assign box_wdata[g] = ch_recall[NCH-1-g] ? ch_head_data[NCH-1-g] : in_data;
            // Pop: read-back for migration, or a sent frame on a live channel.
            assign box_pop[g]   = ch_recall[g] | (ch_sent[g] & ch_head_valid[g]);
            assign ch_head_valid[g] = box_valid[g] & ~ch_fault[g];

            dd_mailbox #(.W(DATA_W), .DEPTH(DEPTH)) u_box (
                .clk        (clk),
                .rst_n      (rst_n),
                .push       (ch_push[g]),
                .push_data  (box_wdata[g]),
                .pop        (box_pop[g]),
                .head_valid (box_valid[g]),
                .head_data  (ch_head_data[g]),
                .count      (box_cnt[g])
            );

            dd_health #(.TEC_W(TEC_W), .POLL_CYCLES(POLL_CYCLES), .TEC_LIMIT(128)) u_health (
                .clk   (clk),
                .rst_n (rst_n),
                .epass (ch_epass[g]),
                .boff  (ch_boff[g]),
                .tec   (ch_tec[g]),
                .fault (ch_fault[g]),
                .probe (ch_probe[g])
            );

            AST_HEAD_WITHHELD: assert property (@(posedge clk) disable iff (!rst_n)
                ch_fault[g] |-> !ch_head_valid[g]); // R5
        end
    endgenerate

    dd_route #(.DEPTH(DEPTH), .IDLE_CYCLES(IDLE_CYCLES)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt0     (box_cnt[PRIMARY]),
        .cnt1     (box_cnt[BACKUP]),
        .fault    (ch_fault),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .enq      (ch_push),
        .recall   (ch_recall)
    );

    // Both channels out of service.
    assign all_down = &ch_fault;

    AST_ALL_DOWN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        all_down |-> (!in_ready && ch_push == 2'b00 && ch_recall == 2'b00)); // R10
    AST_SINGLE_FAULT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_fault == 2'b01 && in_valid && in_ready) |-> (ch_push == 2'b10)); // R7
endmodule

// File: tb/sim_dual_bus_dispatch.sv
module sim_dual_bus_dispatch;
    localparam int DW = 16, DEPTH = 3, TW = 9, POLL = 16, IDLE = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready;
    logic [DW-1:0] in_data = '0;
    logic [1:0] ch_epass = '0, ch_boff = '0, ch_sent = '0;
    logic [1:0][TW-1:0] ch_tec = '0;
    logic [1:0] ch_head_valid, ch_push, ch_recall, ch_probe, ch_fault;
    logic [1:0][DW-1:0] ch_head_data;
    logic all_down;

    always #10 clk = ~clk;

    dual_bus_dispatch #(.DATA_W(DW), .DEPTH(DEPTH), .TEC_W(TW),
                        .POLL_CYCLES(POLL), .IDLE_CYCLES(IDLE)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .ch_epass(ch_epass), .ch_boff(ch_boff),
        .ch_tec(ch_tec), .ch_head_valid(ch_head_valid),
        .ch_head_data(ch_head_data), .ch_sent(ch_sent), .ch_push(ch_push),
        .ch_recall(ch_recall), .ch_probe(ch_probe), .ch_fault(ch_fault),
        .all_down(all_down));

    int n_chk = 0, n_bad = 0;
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state.
    logic [DW-1:0] mq0[$], mq1[$];
    bit [1:0] mf;
    int mp[2];
    int mstreak;
    bit e_ready, e_down;
    bit [1:0] e_hv, e_push, e_recall, e_probe;
    int e_tgt, e_c0, e_c1;
    bit cmp_en = 0;

    // Stimulus controls.
    int src_pct = 0, drain_pct[2] = '{0, 0};
    int seed = 32'h1234_5678;
    bit accepted = 0;
    int tally_bal = 0, tally_rec0 = 0, tally_rec1 = 0, tally_probe0 = 0, tally_p0_flt = 0;
    bit in_flt_window = 0, in_bal_window = 0;

    function automatic int rnd100();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >>> 17);
        seed = seed ^ (seed << 5);
        return (seed & 32'h7fff_ffff) % 100;
    endfunction

    task automatic model_eval();
        int ms;
        e_c0 = mq0.size(); e_c1 = mq1.size();
        e_hv[0] = (e_c0 > 0) && !mf[0];
        e_hv[1] = (e_c1 > 0) && !mf[1];
        e_down = mf[0] && mf[1];
        for (int i = 0; i < 2; i++) e_probe[i] = mf[i] && (mp[i] == POLL - 1);
        ms = -1;
        if (mf[0] && !mf[1] && e_c0 > 0) ms = 0;
        else if (mf[1] && !mf[0] && e_c1 > 0) ms = 1;
        e_recall = '0;
        if (ms == 0 && e_c1 < DEPTH) e_recall[0] = 1;
        if (ms == 1 && e_c0 < DEPTH) e_recall[1] = 1;
        e_tgt = -1;
        if (ms < 0) begin
            if (!mf[0] && !mf[1])
                e_tgt = (e_c0 == DEPTH || (mstreak == IDLE && e_c1 == 0)) ? 1 : 0;
            else if (!mf[0]) e_tgt = 0;
            else if (!mf[1]) e_tgt = 1;
        end
        e_ready = (e_tgt == 0 && e_c0 < DEPTH) || (e_tgt == 1 && e_c1 < DEPTH);
        e_push = '0;
        if (e_recall[0]) e_push[1] = 1;
        if (e_recall[1]) e_push[0] = 1;
        if (in_valid && e_ready) e_push[e_tgt] = 1;
    endtask

    // Compare on the falling edge, after inputs settled.
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            model_eval();
            check(in_ready == e_ready, "R2 in_ready", in_ready, e_ready);
            check(ch_push == e_push, "R2 ch_push", ch_push, e_push);
            check(ch_head_valid == e_hv, "R3 head_valid", ch_head_valid, e_hv);
            if (e_hv[0]) check(ch_head_data[0] == mq0[0], "R3 head_data0", ch_head_data[0], mq0[0]);
            if (e_hv[1]) check(ch_head_data[1] == mq1[0], "R3 head_data1", ch_head_data[1], mq1[0]);
            check(ch_recall == e_recall, "R6 ch_recall", ch_recall, e_recall);
            check(ch_probe == e_probe, "R8 ch_probe", ch_probe, e_probe);
            check(ch_fault == mf, "R5 ch_fault", ch_fault, mf);
            check(all_down == e_down, "R10 all_down", all_down, e_down);
            if (in_bal_window && ch_push[1]) tally_bal++;
            if (ch_recall[0]) tally_rec0++;
            if (ch_recall[1]) tally_rec1++;
            if (ch_probe[0]) tally_probe0++;
            if (in_flt_window && ch_push[0]) tally_p0_flt++;
        end
        accepted = in_valid && in_ready;
    end

    // Model update on the rising edge, using values computed at negedge.
    always @(posedge clk) begin
        if (!rst_n) begin
            mq0.delete(); mq1.delete(); mf = '0; mp = '{0, 0}; mstreak = 0;
        end else if (cmp_en) begin
            logic [DW-1:0] x;
            if (ch_sent[0] && e_hv[0]) void'(mq0.pop_front());
            if (ch_sent[1] && e_hv[1]) void'(mq1.pop_front());
            if (e_recall[0]) begin x = mq0.pop_front(); mq1.push_back(x); end
            if (e_recall[1]) begin x = mq1.pop_front(); mq0.push_back(x); end
            if (in_valid && e_ready) begin
                if (e_tgt == 0) mq0.push_back(in_data); else mq1.push_back(in_data);
            end
            if (!mf[0] && !mf[1] && e_c1 == 0 && e_c0 != 0)
                mstreak = (mstreak < IDLE) ? mstreak + 1 : IDLE;
            else mstreak = 0;
            for (int i = 0; i < 2; i++) begin
                bit bad_i;
                bad_i = ch_epass[i] || ch_boff[i];
                mp[i] = (!mf[i] || e_probe[i]) ? 0 : mp[i] + 1;
                if (bad_i) mf[i] = 1;
                else if (e_probe[i] && ch_tec[i] < 128) mf[i] = 0;
            end
        end
    end

    // Per-cycle source and drain stubs.
    always @(posedge clk) begin
        #1;
        if (accepted) in_data <= in_data + 1'b1;
        in_valid <= (rnd100() < src_pct);
        ch_sent[0] <= (rnd100() < drain_pct[0]);
        ch_sent[1] <= (rnd100() < drain_pct[1]);
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        cycles(4);
        rst_n = 1'b1;
        cmp_en = 1;
        @(negedge clk); #1;
        // R1 reset state
        check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        check(ch_head_valid == 2'b00 && ch_fault == 2'b00 && all_down == 1'b0,
              "R1 idle after reset", {ch_head_valid, ch_fault, all_down}, 0);
        check(ch_probe == 2'b00 && ch_recall == 2'b00, "R1 strobes idle", {ch_probe, ch_recall}, 0);

        // R2 fill both boxes with no draining
        src_pct = 100; cycles(12);
        check(in_ready == 1'b0 && ch_head_valid == 2'b11, "R2 both full stall",
              {in_ready, ch_head_valid}, 2'b011);
        // R3 sent pulses on both channels while streaming
        drain_pct = '{50, 50}; src_pct = 70; cycles(200);
        // R4 backup idle while primary busy
        in_bal_window = 1; drain_pct = '{10, 100}; src_pct = 30; cycles(200);
        in_bal_window = 0;
        check(tally_bal > 0, "R4 frames steered to idle backup", tally_bal, 1);

        // R6 fault primary with pending frames
        drain_pct = '{0, 0}; src_pct = 100; cycles(6);
        src_pct = 0; drain_pct = '{0, 60};
        ch_epass[0] = 1; cycles(20);
        check(tally_rec0 > 0, "R6 pending frames read back", tally_rec0, 1);
        // R7 traffic only to backup
        in_flt_window = 1; src_pct = 60; ch_tec[0] = 200; cycles(60);
        in_flt_window = 0;
        check(tally_p0_flt == 0, "R7 no push to faulted primary", tally_p0_flt, 0);
        check(tally_probe0 >= 3, "R8 probes while faulted", tally_probe0, 3);
        // R9 no recovery with high error counter
        ch_epass[0] = 0; cycles(3 * POLL);
        check(ch_fault[0] == 1'b1, "R9 stays faulted with tec>=128", ch_fault[0], 1);
        ch_tec[0] = 50; cycles(POLL + 2);
        check(ch_fault[0] == 1'b0, "R9 recovered with tec<128", ch_fault[0], 0);

        // R7 symmetric: backup bus-off
        drain_pct = '{0, 0}; src_pct = 100; cycles(8);
        src_pct = 0; drain_pct = '{60, 0};
        ch_boff[1] = 1; cycles(20);
        check(tally_rec1 > 0, "R6 backup frames moved to primary", tally_rec1, 1);
        src_pct = 50; cycles(60);

        // R10 both down
        ch_epass[0] = 1; drain_pct = '{0, 0}; src_pct = 100; cycles(3);
        check(all_down == 1'b1 && in_ready == 1'b0, "R10 all down stall", {all_down, in_ready}, 2'b10);
        cycles(40);
        ch_epass[0] = 0; ch_tec[0] = 0; ch_boff[1] = 0; ch_tec[1] = 0;
        drain_pct = '{50, 50}; src_pct = 50; cycles(3 * POLL);
        check(ch_fault == 2'b00, "R9 both recovered", ch_fault, 0);
        cycles(50);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule